// File: doc/BRIEF.md
# Memory Bit-Invert Unit

This unit carries out an in-place bit-invert operation on a byte-addressed memory. A requester supplies a 32-bit base value, a 16-bit signed displacement and a 3-bit bit index, then pulses `start`. The unit forms the target address and issues one read. It waits for the read data, flips the chosen bit and writes the byte back. It then reports a zero flag that shows the prior state of that bit.

The memory side is a single-master synchronous port. The unit raises `mem_re` for one cycle, waits any number of cycles for `mem_rvalid`, and then drives `mem_we` for one cycle with the modified byte. The unit ignores new requests from the moment it accepts an operation until its `done` pulse.

Top module: `mem_bit_invert`

## Requirements
- R1: The target address is `base_in` plus `disp_in` sign-extended to 32 bits, modulo 2^32, and is sampled in the cycle `start` is accepted.
- R2: `bit_sel` selects bit n of the addressed byte, where n = 0 is the least significant bit.
- R3: The byte written back equals the byte read with only the selected bit inverted.
- R4: `zf_out` is 1 when the selected bit was 0 before the inversion and 0 when it was 1. The unit has no other flag output.
- R5: An accepted start is followed by one `mem_re` cycle, then a wait of any length for `mem_rvalid`, then one `mem_we` cycle, then one `done` cycle, then idle. `mem_rvalid` has no effect outside the wait phase.
- R6: A `start` seen while `busy` is high and `done` is low is ignored, so each accepted operation writes exactly once.
- R7: Changes on `base_in`, `disp_in` or `bit_sel` after acceptance do not alter the address, the bit or the data of the running operation.
- R8: `done` is a single-cycle pulse. `zf_we` is high only in that cycle, and `zf_out` is valid then.
- R9: A synchronous active-high `rst` returns the unit to idle, with `busy`, `mem_re`, `mem_we` and `done` low, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation (taken when idle) |
| base_in | input | 32 | Base register value |
| disp_in | input | 16 | Signed displacement |
| bit_sel | input | 3 | Index of the bit to invert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zf_out | output | 1 | Zero flag result |
| zf_we | output | 1 | Zero flag update enable |
| mem_addr | output | 32 | Memory byte address |
| mem_re | output | 1 | Read request |
| mem_rdata | input | 8 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |

## Verification
The bench builds the unit with the package defaults: 32-bit addresses, 16-bit displacements and 8-bit bytes with a 3-bit index. These defaults allow address wraparound at both ends of the 32-bit space, and negative displacements at full width. The bench's memory model varies its read latency from one to ten cycles per operation. It can also inject stray read-valid pulses while the unit is idle. Together these exercise the open-ended wait, a reset arriving during that wait, and a response that arrives after a reset has aborted the operation.

// File: rtl/bitinv_pkg.sv
package bitinv_pkg;
    localparam int ADDR_W = 32;
    localparam int DISP_W = 16;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_WAIT,
        PH_WR,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
    } op_t;

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction
endpackage

// File: rtl/bitinv_agen.sv
module bitinv_agen
    import bitinv_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] addr
);
    assign addr = base + sext_disp(disp);
endmodule

// File: rtl/bitinv_seq.sv
module bitinv_seq
    import bitinv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rvalid,
    output logic accept,
    output logic capture,
    output logic busy,
    output logic rd_req,
    output logic wr_en,
    output logic done
);
    phase_e ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: if (start)  ph_d = PH_REQ;
            PH_REQ:              ph_d = PH_WAIT;
            PH_WAIT: if (rvalid) ph_d = PH_WR;
            PH_WR:               ph_d = PH_DONE;
            PH_DONE:             ph_d = PH_IDLE;
            default:             ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign accept  = (ph_q == PH_IDLE) && start;
    assign capture = (ph_q == PH_WAIT) && rvalid;
    assign busy    = (ph_q != PH_IDLE);
    assign rd_req  = (ph_q == PH_REQ);
    assign wr_en   = (ph_q == PH_WR);
    assign done    = (ph_q == PH_DONE);

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (!rd_req && busy && !wr_en)); // R5
    AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> done); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!wr_en && !busy && !rd_req && !done)); // R9
endmodule

// File: rtl/bitinv_flip.sv
module bitinv_flip
    import bitinv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BYTE_W-1:0] rdata,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] wdata,
    output logic              zf
);
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst)          byte_q <= '0;
        else if (capture) byte_q <= rdata;
    end

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign wdata[i] = byte_q[i] ^ (idx == IDX_W'(i));
    end

    assign zf = ~byte_q[idx];
endmodule

// File: rtl/mem_bit_invert.sv
module mem_bit_invert
    import bitinv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [DISP_W-1:0] disp_in,
    input  logic [IDX_W-1:0]  bit_sel,
    output logic              busy,
    output logic              done,
    output logic              zf_out,
    output logic              zf_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we
);
    logic [ADDR_W-1:0] tgt_addr;
    logic              accept;
    logic              capture;
    op_t               op_q;

    bitinv_agen u_agen (
        .base (base_in),
        .disp (disp_in),
        .addr (tgt_addr)
    );

    bitinv_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rvalid  (mem_rvalid),
        .accept  (accept),
        .capture (capture),
        .busy    (busy),
        .rd_req  (mem_re),
        .wr_en   (mem_we),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst)         op_q <= '0;
        else if (accept) op_q <= '{addr: tgt_addr, idx: bit_sel};
    end

    bitinv_flip u_flip (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .rdata   (mem_rdata),
        .idx     (op_q.idx),
        .wdata   (mem_wdata),
        .zf      (zf_out)
    );

    assign mem_addr = op_q.addr;
    assign zf_we    = done;

    AST_ADDR_FORMED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (mem_addr == $past(base_in + sext_disp(disp_in)))); // R1
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_re || mem_we) |=> $stable(mem_addr)); // R7
    AST_ZF_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (zf_out == $past(mem_wdata[op_q.idx]))); // R4
    AST_ZFWE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        zf_we |-> done); // R8
endmodule

// File: tb/test_mem_bit_invert.sv
module test_mem_bit_invert;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [31:0] base_in = 0;
    logic [15:0] disp_in = 0;
    logic [2:0]  bit_sel = 0;
    logic        busy, done, zf_out, zf_we, mem_re, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata = 0;
    logic        mem_rvalid = 0;
    logic [7:0]  mem_wdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_bit_invert i_mem_bit_invert (
        .clk(clk), .rst(rst), .start(start), .base_in(base_in), .disp_in(disp_in),
        .bit_sel(bit_sel), .busy(busy), .done(done), .zf_out(zf_out), .zf_we(zf_we),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    // ---------------- memory model ----------------
    logic [7:0] mem [logic [31:0]];
    int         lat = 1;
    int         pend = 0;
    logic [31:0] req_addr = 0;
    int         wr_cnt = 0;
    logic       spur = 0;

    function automatic logic [7:0] rd_mem(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(negedge clk) begin
        mem_rvalid <= spur;
        if (spur) mem_rdata <= 8'hFF;
        if (pend > 0) begin
            if (pend == 1) begin
                mem_rvalid <= 1;
                mem_rdata  <= rd_mem(req_addr);
            end
            pend <= pend - 1;
        end
        if (mem_re) begin
            pend     <= lat;
            req_addr <= mem_addr;
        end
        if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
        end
    end

    // ---------------- cycle reference model ----------------
    int          ph = 0;
    logic [31:0] m_addr = 0;
    logic [2:0]  m_bit = 0;
    logic [7:0]  m_wd = 0;
    logic        m_zf = 0;

    always @(posedge clk) begin
        if (rst) ph = 0;
        else case (ph)
            0: if (start) begin
                   ph = 1;
                   m_addr = base_in + {{16{disp_in[15]}}, disp_in};
                   m_bit = bit_sel;
               end
            1: ph = 2;
            2: if (mem_rvalid) begin
                   ph = 3;
                   m_wd = mem_rdata ^ (8'd1 << m_bit);
                   m_zf = ~mem_rdata[m_bit];
               end
            3: ph = 4;
            default: ph = 0;
        endcase
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    logic model_on = 0;
    always @(negedge clk) begin
        if (model_on) begin
            chk(busy == (ph != 0), "R5 busy", busy, ph != 0);
            chk(mem_re == (ph == 1), "R5 mem_re", mem_re, ph == 1);
            chk(mem_we == (ph == 3), "R5 mem_we", mem_we, ph == 3);
            chk(done == (ph == 4), "R8 done", done, ph == 4);
            chk(zf_we == (ph == 4), "R8 zf_we", zf_we, ph == 4);
            if (ph >= 1 && ph <= 3) chk(mem_addr == m_addr, "R1 R7 mem_addr", mem_addr, m_addr);
            if (ph == 3) chk(mem_wdata == m_wd, "R3 mem_wdata", mem_wdata, m_wd);
            if (ph == 4) chk(zf_out == m_zf, "R4 zf_out", zf_out, m_zf);
        end
    end

    // ---------------- directed operation ----------------
    task automatic run_op(input logic [31:0] b, input logic [15:0] d, input logic [2:0] k,
                          input int l, input bit noise);
        logic [31:0] a;
        logic [7:0]  old;
        int          w0;
        bit          seen;
        a    = b + {{16{d[15]}}, d};
        old  = rd_mem(a);
        w0   = wr_cnt;
        lat  = l;
        seen = 0;
        @(negedge clk);
        base_in = b; disp_in = d; bit_sel = k; start = 1;
        @(negedge clk);
        start = noise;
        if (noise) begin
            base_in = ~b; disp_in = ~d; bit_sel = ~k;
        end
        for (int i = 0; i < 40 && !seen; i++) begin
            if (done) begin
                seen = 1;
                chk(zf_out == ~old[k], "R4 zf at done", zf_out, ~old[k]);
                start = 0;
            end else @(negedge clk);
        end
        start = 0;
        chk(seen, "R5 done reached", seen, 1);
        @(negedge clk);
        chk(rd_mem(a) == (old ^ (8'd1 << k)), "R2 R3 memory byte", rd_mem(a), old ^ (8'd1 << k));
        chk(wr_cnt - w0 == 1, "R6 single write", wr_cnt - w0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_we && !mem_re && !done, "R9 reset state", {busy, mem_we, mem_re, done}, 0);
        rst = 0;
        model_on = 1;

        run_op(32'h0000_1000, 16'h0010, 3'd0, 1, 0);
        run_op(32'h0000_1000, 16'h0010, 3'd0, 1, 0);   // same bit back
        run_op(32'h0000_2000, 16'hFFFF, 3'd7, 3, 0);   // negative disp
        run_op(32'h0000_0005, 16'hFFF0, 3'd4, 2, 0);   // R1 wrap below zero
        run_op(32'hFFFF_FFFF, 16'h0001, 3'd2, 5, 0);   // R1 wrap above top
        run_op(32'h1234_5678, 16'h7FFF, 3'd5, 10, 1);  // R6 R7 start and inputs toggled
        run_op(32'h0000_3000, 16'h8000, 3'd1, 4, 1);
        for (int k = 0; k < 8; k++) run_op(32'h0000_4000, 16'h0003, 3'(k), 1 + k, 0); // R2 each bit

        // R5 stray rvalid while idle is ignored
        @(negedge clk); spur = 1;
        @(negedge clk); spur = 0;
        @(negedge clk);
        chk(!busy && !mem_we, "R5 stray rvalid ignored", busy, 0);
        run_op(32'h0000_5000, 16'h0000, 3'd6, 2, 0);

        // R9 reset in the middle of the read wait
        begin
            int w0;
            w0 = wr_cnt;
            lat = 8;
            @(negedge clk);
            base_in = 32'h0000_6000; disp_in = 0; bit_sel = 3'd3; start = 1;
            @(negedge clk); start = 0;
            repeat (3) @(negedge clk);
            rst = 1;
            @(negedge clk); rst = 0;
            chk(!busy && !mem_we && !done, "R9 reset mid op", {busy, mem_we, done}, 0);
            repeat (15) @(negedge clk);
            chk(wr_cnt == w0, "R9 no write after abort", wr_cnt - w0, 0);
        end
        run_op(32'h0000_6000, 16'h0000, 3'd3, 1, 0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule